// File: doc/BRIEF.md
# Two-Stage Serial Baud Rate Generator

This block produces the timing strobes for an asynchronous serial port from the internal bus clock. Two dividers are chained. The first is a prescaler with a small fixed menu of four divide factors: 1, 3, 4 and 13. Its factor sets the fastest rate the port can reach. The second stage divides the prescaler output by a power of two, from 1 up to 128.

The output of both stages is a receiver timing strobe at sixteen times the serial bit rate. A further divide-by-16 produces a strobe once per serial bit. Both outputs are single-cycle enables in the bus clock domain, not derived clocks. The receiver sampler and the transmit shifter use them as clock enables.

The two select inputs may change at any time. When either select changes, all counters restart from zero, so that no strobe is shortened or stretched. The timing of a frame in progress across such a change is not guaranteed.

Top module: `bdg_baud_gen`

## Requirements
- R1: The prescale select picks the prescale divide factor: code 0 divides by 1, code 1 by 3, code 2 by 4 and code 3 by 13. With the rate select at 0, `rt_tick` fires once every prescale-factor cycles.
- R2: Rate select code r (0 to 7) divides the prescaler output by 2^r. With the prescale select at 0, `rt_tick` fires once every 2^r cycles.
- R3: With both selects held, `rt_tick` is periodic with period P·2^r cycles, where P is the prescale factor. The first strobe after a restart comes in cycle P·2^r − 1, counting the restart cycle as cycle 0.
- R4: With prescale select 0 and rate select 0, `rt_tick` is high in every cycle out of reset.
- R5: `bit_tick` fires only together with `rt_tick`, on every sixteenth `rt_tick` after a restart. Its period is 16·P·2^r cycles.
- R6: A cycle in which either select input differs from its value in the previous cycle is a restart cycle, counted as cycle 0. The strobes then follow R3 and R5 from that cycle on.
- R7: While `rst_n` is low, both strobes are low. The cycle after reset release counts as cycle 0 of a restart.
- R8: Each `bit_tick` lasts one cycle. `rt_tick` is high in two consecutive cycles only while the fastest setting of R4 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 2 | Prescale factor code (0:÷1, 1:÷3, 2:÷4, 3:÷13) |
| rate_sel | input | RATE_SEL_W (3) | Power-of-two rate code, divide by 2^code |
| rt_tick | output | 1 | Receiver timing strobe, 16× the bit rate |
| bit_tick | output | 1 | Bit-rate strobe, one per sixteen `rt_tick` |

## Verification
Both strobes are decoded combinationally from the counter state and the current select inputs. A strobe is therefore due in the same cycle that its count is reached, and a select change takes effect in the cycle the new code is presented. The bench drives the selects on the falling edge and compares the outputs 2 ns later, before the next rising edge. The reference model counts cycles since the last restart and predicts a strobe whenever that count plus one is a multiple of P·2^r, or of 16·P·2^r for `bit_tick`. The model advances only on the rising edge.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

   localparam int unsigned PRE_SEL_W = 2;

   typedef enum logic [PRE_SEL_W-1:0] {
      PRE_F0 = 2'd0,
      PRE_F1 = 2'd1,
      PRE_F2 = 2'd2,
      PRE_F3 = 2'd3
   } pre_code_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bdg_prescaler.sv
module bdg_prescaler
   import bdg_pkg::*;
#(
   parameter int unsigned DIV_0 = 1,
   parameter int unsigned DIV_1 = 3,
   parameter int unsigned DIV_2 = 4,
   parameter int unsigned DIV_3 = 13
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic [PRE_SEL_W-1:0] sel,
   output logic                 tick
);

   localparam int unsigned DMAX = max4(DIV_0, DIV_1, DIV_2, DIV_3);
   localparam int unsigned CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

   generate
      if (DMAX == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] eff;
         logic [CW-1:0] lim;

         always_comb begin
            unique case (pre_code_e'(sel))
               PRE_F0:  lim = CW'(DIV_0 - 1);
               PRE_F1:  lim = CW'(DIV_1 - 1);
               PRE_F2:  lim = CW'(DIV_2 - 1);
               default: lim = CW'(DIV_3 - 1);
            endcase
         end

         assign eff  = restart ? '0 : cnt_q;
         assign tick = (eff == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= eff + CW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/bdg_pow2_div.sv
module bdg_pow2_div #(
   parameter int unsigned SEL_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int unsigned CW = (1 << SEL_W) - 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] eff;
   logic [CW-1:0] lim;

   // thermometer mask: the low 'sel' bits set
   always_comb begin
      for (int i = 0; i < CW; i++) lim[i] = (i < int'(sel));
   end

   assign eff  = restart ? '0 : cnt_q;
   assign tick = adv && (eff == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else if (adv)  cnt_q <= eff + CW'(1);
      else           cnt_q <= eff;
   end

endmodule

// File: rtl/bdg_os_div.sv
module bdg_os_div
   import bdg_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic adv,
   output logic tick
);

   generate
      if (OVERSAMPLE == 1) begin : g_pass
         assign tick = adv;
      end else begin : g_count
         localparam int unsigned CW = $clog2(OVERSAMPLE);
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] eff;

         assign eff  = restart ? '0 : cnt_q;
         assign tick = adv && (eff == CW'(OVERSAMPLE - 1));

         // power-of-two length: wrap from the top value to zero is natural
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (adv) cnt_q <= eff + CW'(1);
            else          cnt_q <= eff;
         end
      end
   endgenerate

endmodule

// File: rtl/bdg_baud_gen.sv
module bdg_baud_gen
   import bdg_pkg::*;
#(
   parameter int unsigned PRE_DIV_0  = 1,
   parameter int unsigned PRE_DIV_1  = 3,
   parameter int unsigned PRE_DIV_2  = 4,
   parameter int unsigned PRE_DIV_3  = 13,
   parameter int unsigned RATE_SEL_W = 3,
   parameter int unsigned OVERSAMPLE = 16
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            presc_sel,
   input  logic [RATE_SEL_W-1:0] rate_sel,
   output logic                  rt_tick,
   output logic                  bit_tick
);

   // elaboration-time parameter checks
   generate
      if (PRE_DIV_0 == 0 || PRE_DIV_1 == 0 || PRE_DIV_2 == 0 || PRE_DIV_3 == 0) begin : g_bad_div
         $error("bdg_baud_gen: prescale factors must be nonzero");
      end
      if (RATE_SEL_W < 1 || RATE_SEL_W > 5) begin : g_bad_rate
         $error("bdg_baud_gen: RATE_SEL_W must be 1..5");
      end
      if (!is_pow2(OVERSAMPLE)) begin : g_bad_os
         $error("bdg_baud_gen: OVERSAMPLE must be a power of two");
      end
   endgenerate

   logic [PRE_SEL_W-1:0]  pre_q;
   logic [RATE_SEL_W-1:0] rate_q;
   logic                  restart;
   logic                  pre_tick;
   logic                  rt_raw;
   logic                  bit_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         rate_q <= '0;
      end else begin
         pre_q  <= presc_sel;
         rate_q <= rate_sel;
      end
   end

   assign restart = (presc_sel != pre_q) || (rate_sel != rate_q);

   bdg_prescaler #(
      .DIV_0 (PRE_DIV_0),
      .DIV_1 (PRE_DIV_1),
      .DIV_2 (PRE_DIV_2),
      .DIV_3 (PRE_DIV_3)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .sel     (presc_sel),
      .tick    (pre_tick)
   );

   bdg_pow2_div #(
      .SEL_W (RATE_SEL_W)
   ) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .adv     (pre_tick),
      .sel     (rate_sel),
      .tick    (rt_raw)
   );

   bdg_os_div #(
      .OVERSAMPLE (OVERSAMPLE)
   ) u_os (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .adv     (rt_raw),
      .tick    (bit_raw)
   );

   assign rt_tick  = rst_n & rt_raw;
   assign bit_tick = rst_n & bit_raw;

endmodule

// File: rtl/bdg_baud_chk.sv
module bdg_baud_chk #(
   parameter int unsigned RATE_SEL_W = 3
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            presc_sel,
   input logic [RATE_SEL_W-1:0] rate_sel,
   input logic                  rt_tick,
   input logic                  bit_tick
);

   logic fastest;
   assign fastest = (presc_sel == '0) && (rate_sel == '0);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst_n) (!rt_tick && !bit_tick)); // R7
   AST_FAST_EVERY: assert property (@(posedge clk) disable iff (!rst_n) fastest |-> rt_tick); // R4
   AST_BIT_WITH_RT: assert property (@(posedge clk) disable iff (!rst_n) bit_tick |-> rt_tick); // R5
   AST_RT_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (rt_tick && $past(rt_tick)) |-> fastest); // R8
   AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_tick |-> !$past(bit_tick)); // R8
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ((presc_sel != $past(presc_sel) || rate_sel != $past(rate_sel)) && !fastest) |-> !rt_tick); // R6

endmodule

bind bdg_baud_gen bdg_baud_chk #(
   .RATE_SEL_W (RATE_SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .presc_sel (presc_sel),
   .rate_sel  (rate_sel),
   .rt_tick   (rt_tick),
   .bit_tick  (bit_tick)
);

// File: tb/bdg_baud_gen_test.sv
module bdg_baud_gen_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] psel;
   logic [2:0] rsel;
   logic       rt;
   logic       bt;

   always #4 clk = ~clk;   // 125 MHz

   bdg_baud_gen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .presc_sel (psel),
      .rate_sel  (rsel),
      .rt_tick   (rt),
      .bit_tick  (bt)
   );

   int  checks = 0;
   int  fails  = 0;
   int  n_q    = 0;
   int  prev_p = 0;
   int  prev_r = 0;
   int  eff_s  = 0;
   bit  prev_bt = 1'b0;
   bit  done   = 1'b0;

   function automatic int pfac(input int p);
      case (p)
         0: return 1;
         1: return 3;
         2: return 4;
         default: return 13;
      endcase
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual=%0b expected=%0b (psel=%0d rsel=%0d)",
                  tag, $time, act, exp, psel, rsel);
      end
   endtask

   // reference: cycles since the last restart
   always @(posedge clk) begin
      if (!rst_n) begin
         n_q = 0; prev_p = 0; prev_r = 0;
      end else begin
         n_q = eff_s + 1; prev_p = int'(psel); prev_r = int'(rsel);
      end
   end

   task automatic step(input int p, input int r, input logic rn);
      int    per;
      bit    restart;
      bit    exp_rt;
      bit    exp_bt;
      string tag;
      @(negedge clk);
      rst_n = rn; psel = 2'(p); rsel = 3'(r);
      #2;
      if (!rst_n) begin
         chk("R7 rt_tick in reset", rt, 1'b0);
         chk("R7 bit_tick in reset", bt, 1'b0);
      end else begin
         restart = (p != prev_p) || (r != prev_r);
         eff_s   = restart ? 0 : n_q;
         per     = pfac(p) * (1 << r);
         exp_rt  = ((eff_s + 1) % per) == 0;
         exp_bt  = ((eff_s + 1) % (per * 16)) == 0;
         if (restart)             tag = "R6 rt_tick after select change";
         else if (p == 0 && r == 0) tag = "R4 rt_tick fastest";
         else if (r == 0)         tag = "R1 rt_tick prescale only";
         else if (p == 0)         tag = "R2 rt_tick rate only";
         else                     tag = "R3 rt_tick cascaded";
         chk(tag, rt, exp_rt);
         chk(restart ? "R6 bit_tick after select change" : "R5 bit_tick", bt, exp_bt);
         chk("R8 bit_tick single cycle", logic'(bt && prev_bt), 1'b0);
      end
      prev_bt = bt;
   endtask

   task automatic run(input int p, input int r, input int n);
      for (int i = 0; i < n; i++) step(p, r, 1'b1);
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0; psel = 2'd2; rsel = 3'd5;
      for (int i = 0; i < 4; i++) step(2, 5, 1'b0);          // R7 selects held during reset
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 3; k++) begin
            int r;
            r = (k == 0) ? 0 : ((k == 1) ? 1 : 3);
            run(p, r, 32 * pfac(p) * (1 << r) + 3);
         end
      end
      run(3, 7, 16 * 13 * 128 + 5);                           // R3 slowest setting
      run(2, 2, 37);
      run(1, 1, 10);                                          // R6 mid-count change
      for (int i = 0; i < 20; i++) step((i % 2) ? 3 : 1, 1, 1'b1); // R6 restart every cycle
      run(0, 0, 5);
      run(0, 1, 5);
      run(2, 0, 9);
      step(1, 0, 1'b0);                                       // R7 reset mid-run
      step(1, 0, 1'b0);
      run(1, 0, 60);
      run(0, 0, 40);                                          // R4 and R5 at fastest rate
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_up();
   end

endmodule